// File: doc/BRIEF.md
# Dithered Resistor-Ladder Switch Modulator

This block turns a fine-grained resistance setting into the gate pattern for a bank of switches that short the taps of a resistor ladder. The setting is a fixed-point word: the integer field chooses how many switches are closed, and the fractional field is the fraction of samples in which one more switch is closed. A first-order error-feedback accumulator chooses, sample by sample, between the integer setting and that setting plus one. The long-run average switch count therefore equals the full fixed-point value, and only the single switch at the boundary ever toggles.

The block steps once for each cycle in which the clock enable is high. In a typical system that enable pulses once every 64 cycles of a 2 MHz clock, which gives a loop rate of 31.25 kHz. The outputs are active low, because the switches conduct when their gate is low. A count of k drives the lowest k lines low. All lines high leaves the ladder at its maximum resistance, and all lines low gives the minimum.

Top module: `ladder_dither_mod`

## Requirements
- R1: While reset is high, and in the first output after it, all switch lines are high. Reset also clears the fractional error, so with a fraction of exactly one half (0x400) the first enabled sample gives the integer count and the second gives the integer count plus one.
- R2: A closed count k drives sw_n[k-1:0] low and leaves sw_n[31:k] high. The lines always form a thermometer code.
- R3: Each enabled sample closes either the integer count or the integer count plus one. The integer is ctrl_word[15:11] and the fraction is ctrl_word[10:0]. The output register adds one cycle of delay.
- R4: With a fraction of zero, every enabled sample closes exactly the integer count.
- R5: With a constant word and the error cleared by reset, exactly frac of any 2048 consecutive enabled samples take the plus-one setting.
- R6: While ce is low, sw_n and the fractional error hold their values. When ce returns high, the sequence continues from where it stopped.
- R7: With an integer of 31, the plus-one case closes all 32 switches and never wraps to fewer.
- R8: With a word of zero, every switch stays open.
- R9: While the word is unchanged, two consecutive outputs differ in at most one switch line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; one modulator step per high cycle |
| ctrl_word | input | 16 | Setting: [15:11] integer switch count, [10:0] fraction |
| sw_n | output | 32 | Active-low switch gates, thermometer coded from bit 0 |

## Verification
The fractional error register is the only hidden state, and a fault in it shows only in the timing of the plus-one samples. A wrong reset value shifts the phase, which is visible on the first two samples of a half-fraction word. A lost carry or a wrong width shows up as a wrong count of plus-one samples over a 2048-sample window. A fault in the count or encoder path appears within one enabled cycle, as a line pattern that is not a thermometer code or as a count outside the integer/integer-plus-one window.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  localparam int LDM_LEGS   = 32;
  localparam int LDM_FRAC_W = 11;
  localparam int LDM_INT_W  = $clog2(LDM_LEGS);

  function automatic int ldm_cnt_w(input int legs);
    return $clog2(legs + 1);
  endfunction
endpackage

// File: rtl/ldm_err_acc.sv
module ldm_err_acc #(
  parameter int LEGS   = 32,
  parameter int INT_W  = 5,
  parameter int FRAC_W = 11,
  localparam int CNT_W = $clog2(LEGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [FRAC_W-1:0] err_q;
  logic [FRAC_W:0]   sum;
  logic              carry;
  logic [CNT_W:0]    raw;

  // error feedback: the residue of each sample is carried into the next
  always_comb begin
    sum   = {1'b0, err_q} + {1'b0, frac_i};
    carry = sum[FRAC_W];
    raw   = (CNT_W + 1)'(int_i) + (CNT_W + 1)'(carry);
    if (raw > (CNT_W + 1)'(LEGS)) cnt_o = CNT_W'(LEGS);
    else                          cnt_o = raw[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     err_q <= '0;
    else if (ce) err_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/ldm_therm_enc.sv
module ldm_therm_enc #(
  parameter int LEGS   = 32,
  localparam int CNT_W = $clog2(LEGS + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LEGS-1:0]  close_o
);
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    assign close_o[g] = (cnt_i > CNT_W'(g));
  end
endmodule

// File: rtl/ladder_dither_mod.sv
module ladder_dither_mod
  import ldm_pkg::*;
#(
  parameter int LEGS   = LDM_LEGS,
  parameter int FRAC_W = LDM_FRAC_W,
  localparam int INT_W = $clog2(LEGS),
  localparam int CW_W  = INT_W + FRAC_W,
  localparam int CNT_W = $clog2(LEGS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic [CW_W-1:0] ctrl_word,
  output logic [LEGS-1:0] sw_n
);
  logic [CNT_W-1:0] cnt;
  logic [LEGS-1:0]  close_v;

  ldm_err_acc #(.LEGS(LEGS), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .int_i  (ctrl_word[CW_W-1:FRAC_W]),
    .frac_i (ctrl_word[FRAC_W-1:0]),
    .cnt_o  (cnt)
  );

  ldm_therm_enc #(.LEGS(LEGS)) u_enc (
    .cnt_i   (cnt),
    .close_o (close_v)
  );

  // registered, active-low gate drive; reset opens every switch
  always_ff @(posedge clk) begin
    if (rst)     sw_n <= '1;
    else if (ce) sw_n <= ~close_v;
  end
endmodule

// File: rtl/ladder_dither_mod_chk.sv
module ladder_dither_mod_chk #(
  parameter int LEGS   = 32,
  parameter int FRAC_W = 11,
  localparam int INT_W = $clog2(LEGS),
  localparam int CW_W  = INT_W + FRAC_W
) (
  input logic            clk,
  input logic            rst,
  input logic            ce,
  input logic [CW_W-1:0] ctrl_word,
  input logic [LEGS-1:0] sw_n
);
  logic [LEGS-1:0] closed;
  int unsigned     n_closed;
  int unsigned     lo_n;
  int unsigned     hi_n;
  assign closed   = ~sw_n;
  assign n_closed = $countones(closed);
  assign lo_n = (int'(ctrl_word[CW_W-1:FRAC_W]) > LEGS) ? LEGS : int'(ctrl_word[CW_W-1:FRAC_W]);
  assign hi_n = (lo_n + 1 > LEGS) ? LEGS : lo_n + 1;

  // R1
  reset_open_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&sw_n));

  // R2
  thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ((closed & (closed + LEGS'(1))) == '0));

  // R3 R7
  count_window_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (n_closed == $past(lo_n) || n_closed == $past(hi_n)));

  // R4
  whole_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && ctrl_word[FRAC_W-1:0] == '0) |=> (n_closed == $past(lo_n)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sw_n));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && $past(ce) && !$past(rst) && ctrl_word == $past(ctrl_word))
      |=> ($countones(sw_n ^ $past(sw_n)) <= 1));
endmodule

bind ladder_dither_mod ladder_dither_mod_chk #(.LEGS(LEGS), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .ctrl_word (ctrl_word),
  .sw_n      (sw_n)
);

// File: tb/ladder_dither_mod_bench.sv
module ladder_dither_mod_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce  = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [31:0] sw_n;
  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ladder_dither_mod u_ladder_dither_mod (
    .clk(clk), .rst(rst), .ce(ce), .ctrl_word(ctrl_word), .sw_n(sw_n)
  );

  function automatic int closed_n(input logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) if (!v[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] therm_n(input int k);
    logic [31:0] r = '1;
    for (int i = 0; i < 32; i++) if (i < k) r[i] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ce = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one enabled step; sample after the register has updated
  task automatic step(output logic [31:0] v);
    ce = 1'b1;
    @(posedge clk); @(negedge clk);
    v = sw_n;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    ctrl_word = {5'd20, 11'h3FF};
    @(negedge clk); rst = 1'b1; ce = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 open in reset", sw_n, 32'hFFFF_FFFF);
    rst = 1'b0; ce = 1'b0;
    @(negedge clk);
    check("R1 open after reset", sw_n, 32'hFFFF_FFFF);
    ctrl_word = {5'd10, 11'h400};
    step(v); check("R1 cleared error first", v, therm_n(10));
    step(v); check("R1 cleared error second", v, therm_n(11));
    step(v); check("R3 alternation", v, therm_n(10));
    ce = 1'b0;
  endtask

  task automatic t_whole();
    logic [31:0] v;
    do_reset();
    ctrl_word = {5'd7, 11'h000};
    for (int i = 0; i < 4; i++) begin
      step(v); check("R4 R2 integer only", v, therm_n(7));
    end
    ctrl_word = {5'd19, 11'h000};
    step(v); check("R2 thermometer 19", v, therm_n(19));
    ce = 1'b0;
  endtask

  task automatic t_average();
    logic [31:0] v;
    int ups = 0;
    int prev = -1;
    do_reset();
    ctrl_word = {5'd5, 11'h123};
    for (int i = 0; i < 2048; i++) begin
      step(v);
      if (closed_n(v) == 6) ups++;
      n_chk++;
      if (!(v == therm_n(5) || v == therm_n(6))) begin
        n_fail++;
        $display("FAIL R3 actual=%h expected=%h or %h", v, therm_n(5), therm_n(6));
      end
      if (prev >= 0) begin
        n_chk++;
        if ((closed_n(v) - prev > 1) || (prev - closed_n(v) > 1)) begin
          n_fail++;
          $display("FAIL R9 actual=%0d expected within 1 of %0d", closed_n(v), prev);
        end
      end
      prev = closed_n(v);
    end
    check("R5 plus-one count", 32'(ups), 32'h123);
    ce = 1'b0;
  endtask

  task automatic t_hold();
    logic [31:0] v;
    do_reset();
    ctrl_word = {5'd3, 11'h400};
    step(v); check("R6 before hold", v, therm_n(3));
    ce = 1'b0;
    ctrl_word = {5'd25, 11'h000};
    repeat (5) @(negedge clk);
    check("R6 held output", sw_n, therm_n(3));
    ctrl_word = {5'd3, 11'h400};
    step(v); check("R6 error kept", v, therm_n(4));
    ce = 1'b0;
  endtask

  task automatic t_top();
    logic [31:0] v;
    int full = 0;
    do_reset();
    ctrl_word = {5'd31, 11'h7FF};
    for (int i = 0; i < 16; i++) begin
      step(v);
      if (v == 32'h0) full++;
      n_chk++;
      if (!(v == therm_n(31) || v == 32'h0)) begin
        n_fail++;
        $display("FAIL R7 actual=%h expected=%h or 00000000", v, therm_n(31));
      end
    end
    check("R7 saturates at all closed", 32'(full > 0), 32'd1);
    ce = 1'b0;
  endtask

  task automatic t_bottom();
    logic [31:0] v;
    do_reset();
    ctrl_word = 16'h0000;
    for (int i = 0; i < 4; i++) begin
      step(v); check("R8 all open", v, 32'hFFFF_FFFF);
    end
    ce = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_whole();
    t_average();
    t_hold();
    t_top();
    t_bottom();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule